// File: doc/BRIEF.md
# Invert-Based Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit for a simple datapath. It takes two operands and a 4-bit control code from the instruction decoder, and it returns a result word and a zero flag. The control code has three fields. The top bit inverts operand A. The next bit inverts operand B. The low two bits choose which of four shared paths drives the result: bitwise AND, bitwise OR, the adder sum, or a signed less-than bit.

The block has no separate units for subtraction, NOR or set-less-than. Each of these comes from inverting one or both operands in front of the shared paths:

- Subtraction: B is inverted and the adder carry-in is set to one.
- NOR: both operands are inverted and then ANDed.
- Less-than: the sign of the difference, corrected for overflow, goes to bit 0 of the result.

The zero flag lets a branch-if-equal decision read the outcome of a subtraction directly.

Top module: `inv_alu`

## Requirements
- R1: Control bit 3 (A-invert) set to 1 makes every path use the bitwise complement of A. With code 1000 the result is (~A) & B.
- R2: Control bit 2 (B-invert) set to 1 makes every path use the bitwise complement of B, and the adder carry-in then equals 1. With code 0100 the result is A & ~B.
- R3: With both invert bits clear, select 00 (code 0000) gives A & B, and select 01 (code 0001) gives A | B.
- R4: Code 0010 gives A + B modulo 2^32 with carry-in 0; the carry out of bit 31 is dropped, so 0xFFFFFFFF + 1 gives 0.
- R5: Code 0110 gives A - B modulo 2^32, which is A + ~B + 1.
- R6: Code 1100 gives ~(A | B).
- R7: Code 0111 gives 1 in bit 0 when A is less than B as signed two's-complement values, and 0 otherwise. This holds even when A - B overflows. Bits 31:1 are always 0 under select 11.
- R8: The zero flag is 1 exactly when all 32 result bits are 0. For example, code 0110 with A equal to B raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | Control code: bit 3 A-invert, bit 2 B-invert, bits 1:0 result select (00 AND, 01 OR, 10 sum, 11 less-than) |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The hardest case to reach is a less-than comparison whose subtraction overflows. In that case the raw sign bit of the difference gives the wrong answer, and only the overflow correction gives the right one. Random operands seldom land there. The stimulus therefore pairs the most negative value with a small positive B, and the most positive value with minus one, so that the difference wraps in both directions. Non-overflowing pairs and equal operands are also applied, to show that the less-than bit clears and the zero flag rises.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned A_INV_BIT = 3;
  localparam int unsigned B_INV_BIT = 2;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } res_sel_e;
endpackage

// File: rtl/inv_alu_cond_inv.sv
module inv_alu_cond_inv #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] val_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign val_o[i] = val_i[i] ^ inv_i;
  end
endmodule

// File: rtl/inv_alu_adder.sv
module inv_alu_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK_W = 8
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             less_o
);
  localparam int unsigned NUM_BLK = WIDTH / BLK_W;

  logic [NUM_BLK:0] carry;
  logic             msb_cin;
  logic             ovf;

  assign carry[0] = cin_i;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    assign {carry[k+1], sum_o[k*BLK_W +: BLK_W]} =
        {1'b0, op_a_i[k*BLK_W +: BLK_W]} +
        {1'b0, op_b_i[k*BLK_W +: BLK_W]} +
        {{BLK_W{1'b0}}, carry[k]};
  end

  // carry into the sign bit, recovered from the sign-bit sum
  assign msb_cin = op_a_i[WIDTH-1] ^ op_b_i[WIDTH-1] ^ sum_o[WIDTH-1];
  assign ovf     = carry[NUM_BLK] ^ msb_cin;
  assign less_o  = sum_o[WIDTH-1] ^ ovf;
endmodule

// File: rtl/inv_alu_result_mux.sv
module inv_alu_result_mux
  import inv_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  res_sel_e         sel_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             less_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = and_i;
      SEL_OR:  res_o = or_i;
      SEL_SUM: res_o = sum_i;
      default: res_o = {{(WIDTH-1){1'b0}}, less_i};
    endcase
  end
endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import inv_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK_W = 8
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o
);
  logic [WIDTH-1:0] op_a, op_b;
  logic [WIDTH-1:0] and_res, or_res, sum_res;
  logic             less_bit;
  res_sel_e         sel;

  assign sel = res_sel_e'(ctrl_i[1:0]);

  inv_alu_cond_inv #(.WIDTH(WIDTH)) u_inv_a (
    .val_i(a_i), .inv_i(ctrl_i[A_INV_BIT]), .val_o(op_a)
  );

  inv_alu_cond_inv #(.WIDTH(WIDTH)) u_inv_b (
    .val_i(b_i), .inv_i(ctrl_i[B_INV_BIT]), .val_o(op_b)
  );

  assign and_res = op_a & op_b;
  assign or_res  = op_a | op_b;

  // B-invert doubles as carry-in: ~B + 1 is the two's complement
  inv_alu_adder #(.WIDTH(WIDTH), .BLK_W(BLK_W)) u_add (
    .op_a_i(op_a), .op_b_i(op_b), .cin_i(ctrl_i[B_INV_BIT]),
    .sum_o(sum_res), .less_o(less_bit)
  );

  inv_alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_i(sel), .and_i(and_res), .or_i(or_res), .sum_i(sum_res),
    .less_i(less_bit), .res_o(result_o)
  );

  assign zero_o = ~|result_o;
endmodule

// File: rtl/inv_alu_chk.sv
module inv_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       ctrl_i,
  input logic [WIDTH-1:0] result_i,
  input logic             zero_i
);
  always_comb begin
    // R3
    and_op_chk: assert (ctrl_i != 4'b0000 || result_i == (a_i & b_i))
      else $error("and_op_chk");
    // R3
    or_op_chk: assert (ctrl_i != 4'b0001 || result_i == (a_i | b_i))
      else $error("or_op_chk");
    // R1
    a_inv_chk: assert (ctrl_i != 4'b1000 || result_i == (~a_i & b_i))
      else $error("a_inv_chk");
    // R4
    add_op_chk: assert (ctrl_i != 4'b0010 || result_i == a_i + b_i)
      else $error("add_op_chk");
    // R5
    sub_op_chk: assert (ctrl_i != 4'b0110 || result_i == a_i - b_i)
      else $error("sub_op_chk");
    // R6
    nor_op_chk: assert (ctrl_i != 4'b1100 || result_i == ~(a_i | b_i))
      else $error("nor_op_chk");
    // R7
    slt_hi_chk: assert (ctrl_i[1:0] != 2'b11 || result_i[WIDTH-1:1] == '0)
      else $error("slt_hi_chk");
    // R7
    slt_val_chk: assert (ctrl_i != 4'b0111 ||
                         result_i[0] == ($signed(a_i) < $signed(b_i)))
      else $error("slt_val_chk");
    // R8
    eq_zero_chk: assert (!(ctrl_i == 4'b0110 && a_i == b_i) || zero_i)
      else $error("eq_zero_chk");
  end
endmodule

bind inv_alu inv_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i(a_i), .b_i(b_i), .ctrl_i(ctrl_i), .result_i(result_o), .zero_i(zero_o)
);

// File: tb/inv_alu_tb_top.sv
module inv_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  ctrl;
  logic        zero;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  inv_alu dut_i (.a_i(a), .b_i(b), .ctrl_i(ctrl), .result_o(res), .zero_o(zero));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    ctrl = c; a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    ctrl = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset result", res, 32'h0);
    chk("R8 reset zero", {31'b0, zero}, 32'h1);
    rst_ni = 1'b1;
  endtask

  task automatic t_logic;
    apply(4'b0000, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R3 and", res, 32'hF000_0034);
    apply(4'b0001, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R3 or", res, 32'hFFF0_12FF);
    apply(4'b1000, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R1 ainv and", res, 32'h0F00_00CB);
    apply(4'b0100, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R2 binv and", res, 32'h00F0_1200);
  endtask

  task automatic t_add;
    apply(4'b0010, 32'h1234_5678, 32'h1111_1111);
    chk("R4 add", res, 32'h2345_6789);
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
    chk("R4 add wrap", res, 32'h0);
    chk("R8 zero on wrap", {31'b0, zero}, 32'h1);
    apply(4'b0010, 32'h0000_00FF, 32'h0000_0001);
    chk("R4 block carry", res, 32'h0000_0100);
  endtask

  task automatic t_sub;
    apply(4'b0110, 32'h0000_0010, 32'h0000_0003);
    chk("R5 sub", res, 32'h0000_000D);
    chk("R8 nonzero", {31'b0, zero}, 32'h0);
    apply(4'b0110, 32'h0000_0003, 32'h0000_0010);
    chk("R5 sub negative", res, 32'hFFFF_FFF3);
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    chk("R8 equal zero", {31'b0, zero}, 32'h1);
    chk("R2 carry in", res, 32'h0);
  endtask

  task automatic t_nor;
    apply(4'b1100, 32'h0F0F_0000, 32'h00FF_0001);
    chk("R6 nor", res, 32'hF000_FFFE);
  endtask

  task automatic t_slt;
    apply(4'b0111, 32'h0000_0003, 32'h0000_0005);
    chk("R7 lt small", res, 32'h1);
    apply(4'b0111, 32'h0000_0005, 32'h0000_0003);
    chk("R7 gt small", res, 32'h0);
    chk("R8 slt false zero", {31'b0, zero}, 32'h1);
    apply(4'b0111, 32'hFFFF_FFFE, 32'h0000_0001);
    chk("R7 neg vs pos", res, 32'h1);
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001);
    chk("R7 overflow min", res, 32'h1);
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    chk("R7 overflow max", res, 32'h0);
    apply(4'b0111, 32'h1234_0000, 32'h1234_0000);
    chk("R7 equal", res, 32'h0);
  endtask

  initial begin
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_nor();
    t_slt();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule